// File: doc/BRIEF.md
# Special event interrupt aggregator

This block gathers a few rare link-layer events into one event-status register and drives one level interrupt. There are two global events: a multicast control symbol seen on any port, and a port-write request received on any port. Each of the serial ports also has an error event. Every event is raised by single-cycle pulses on dedicated source inputs. Each pulse is also held in sticky source bits that software can read.

After an interrupt, clearing the status bit alone is not enough to re-arm detection. A status bit sets only on the rising edge of its source condition. That condition is the OR of its sticky source bits and, for a port, a per-port summary bit. Software must therefore also clear the sticky sources, and for a port it must clear the summary bit last. Until then, further pulses update the sticky bits but raise no new status bit. A simple register port gives write access and combinational read access to every register.

Top module: `sev_aggregator`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: A pulse on `ev_mcast_i` sets status bit 0 (address 0) and mode bit 4 (address 3). A pulse on `ev_pwrite_i` sets status bit 1 and mode bit 0. Both results are readable at the first clock edge after the pulse.
- R3: For port n (n = 0..2), a fatal, degraded-threshold or failed-threshold pulse sets bit 2, 24 or 25 of the error word at address 4+2n. An illegal-transaction or max-retry pulse sets bit 20 or 16 of the control word at address 5+2n. Any of these pulses also sets summary bit 6 of that control word and status bit 8+n.
- R4: Writing 1 to a bit of the clear register (address 1, which reads 0) clears the same status bit. Writing 0 leaves the status bit unchanged.
- R5: While mode bit 4 (or bit 0) is still set, a further multicast (or port-write) pulse does not set the cleared status bit again. Once the mode bit has been cleared by writing 1 to it, the next pulse does set the status bit.
- R6: A port's status bit can set again only after all of that port's source bits and its summary bit are zero. If the summary bit is written with 1 while any source bit is still set, it stays 1.
- R7: When an event and a write-1 clear hit the same status or sticky bit in the same cycle, the bit ends up set.
- R8: `irq_o` is high exactly when some status bit and the matching bit of the enable register (address 2) are both 1.
- R9: The enable register reads back the value written to it at the implemented positions (bits 0, 1 and 8..10). Writing 0 to any sticky source or summary bit has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 32 | Combinational read data |
| ev_mcast_i | input | 1 | Multicast control symbol pulse |
| ev_pwrite_i | input | 1 | Port-write request pulse |
| pe_fatal_i | input | 3 | Per-port fatal error pulse |
| pe_degr_i | input | 3 | Per-port degraded threshold pulse |
| pe_fail_i | input | 3 | Per-port failed threshold pulse |
| pe_illeg_i | input | 3 | Per-port illegal transaction pulse |
| pe_retry_i | input | 3 | Per-port max retry pulse |
| irq_o | output | 1 | Aggregated interrupt |

## Verification
Every result is due one clock edge after its stimulus. An event pulse or register write held for one cycle updates the status, sticky and summary registers at the next rising edge. The read data and the interrupt follow through combinational logic only. The bench therefore drives stimulus on a falling edge, lets one rising edge pass, and reads the registers and `irq_o` just after the following falling edge. The sweep over every port and every source kind follows this timing, and so do the same-cycle set/clear cases.

// File: rtl/sev_pkg.sv
package sev_pkg;
    localparam int DW   = 32;
    localparam int AW   = 4;
    localparam int NSRC = 5;

    // register addresses; port n uses PORT_BASE+2n (errors) and +1 (control)
    localparam logic [AW-1:0] A_STAT    = 4'd0;
    localparam logic [AW-1:0] A_CLR     = 4'd1;
    localparam logic [AW-1:0] A_EN      = 4'd2;
    localparam logic [AW-1:0] A_MODE    = 4'd3;
    localparam int            PORT_BASE = 4;

    // status positions
    localparam int B_MCAST = 0;
    localparam int B_PWR   = 1;
    localparam int B_PERR0 = 8;

    // mode source positions
    localparam int M_MCAST = 4;
    localparam int M_PWR   = 0;

    // per-port source positions
    localparam int E_FATAL = 2;
    localparam int E_DEGR  = 24;
    localparam int E_FAIL  = 25;
    localparam int C_SUMM  = 6;
    localparam int C_RETRY = 16;
    localparam int C_ILLEG = 20;

    // order of the per-port source vector
    localparam int S_FATAL = 0;
    localparam int S_DEGR  = 1;
    localparam int S_FAIL  = 2;
    localparam int S_ILLEG = 3;
    localparam int S_RETRY = 4;

    typedef struct packed {
        logic [NSRC-1:0] src;
        logic            summ;
    } port_st_t;

    typedef struct packed {
        logic mc;
        logic pw;
    } mode_st_t;

    typedef struct packed {
        logic [DW-1:0] stat;
        logic [DW-1:0] en;
    } top_st_t;
endpackage

// File: rtl/sev_mode_src.sv
module sev_mode_src
    import sev_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_mc,
    input  logic          ev_pw,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] word,
    output logic          det_mc,
    output logic          det_pw
);
    mode_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.mc = (st_q.mc & ~(we & wdata[M_MCAST])) | ev_mc;
        st_d.pw = (st_q.pw & ~(we & wdata[M_PWR]))   | ev_pw;
        det_mc  = ev_mc & ~st_q.mc;
        det_pw  = ev_pw & ~st_q.pw;
        word          = '0;
        word[M_MCAST] = st_q.mc;
        word[M_PWR]   = st_q.pw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    mc_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.mc) |-> $past(ev_mc));
    // R5
    mc_no_redetect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mc |-> !det_mc);
endmodule

// File: rtl/sev_port_err.sv
module sev_port_err
    import sev_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] ev,
    input  logic            err_we,
    input  logic            ctl_we,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   err_word,
    output logic [DW-1:0]   ctl_word,
    output logic            detect
);
    port_st_t        st_d, st_q;
    logic [NSRC-1:0] clr;
    logic            summ_clr;

    always_comb begin
        clr          = '0;
        clr[S_FATAL] = err_we & wdata[E_FATAL];
        clr[S_DEGR]  = err_we & wdata[E_DEGR];
        clr[S_FAIL]  = err_we & wdata[E_FAIL];
        clr[S_ILLEG] = ctl_we & wdata[C_ILLEG];
        clr[S_RETRY] = ctl_we & wdata[C_RETRY];
        summ_clr     = ctl_we & wdata[C_SUMM];

        st_d      = st_q;
        st_d.src  = (st_q.src & ~clr) | ev;
        // summary is re-asserted by any source still present this cycle
        st_d.summ = (st_q.summ & ~summ_clr) | (|st_q.src) | (|ev);
        detect    = (|ev) & ~st_q.summ & ~(|st_q.src);

        err_word          = '0;
        err_word[E_FATAL] = st_q.src[S_FATAL];
        err_word[E_DEGR]  = st_q.src[S_DEGR];
        err_word[E_FAIL]  = st_q.src[S_FAIL];
        ctl_word          = '0;
        ctl_word[C_SUMM]  = st_q.summ;
        ctl_word[C_ILLEG] = st_q.src[S_ILLEG];
        ctl_word[C_RETRY] = st_q.src[S_RETRY];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6
    summ_covers_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|st_q.src) |-> st_q.summ);
    // R3
    summ_rise_from_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.summ) |-> $past(|ev));
endmodule

// File: rtl/sev_aggregator.sv
module sev_aggregator
    import sev_pkg::*;
#(
    parameter int NPORTS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [DW-1:0]     wr_data_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [DW-1:0]     rd_data_o,
    input  logic              ev_mcast_i,
    input  logic              ev_pwrite_i,
    input  logic [NPORTS-1:0] pe_fatal_i,
    input  logic [NPORTS-1:0] pe_degr_i,
    input  logic [NPORTS-1:0] pe_fail_i,
    input  logic [NPORTS-1:0] pe_illeg_i,
    input  logic [NPORTS-1:0] pe_retry_i,
    output logic              irq_o
);
    function automatic logic [DW-1:0] impl_mask();
        logic [DW-1:0] m;
        m = '0;
        m[B_MCAST] = 1'b1;
        m[B_PWR]   = 1'b1;
        for (int i = 0; i < NPORTS; i++) m[B_PERR0+i] = 1'b1;
        return m;
    endfunction
    localparam logic [DW-1:0] MASK = impl_mask();

    top_st_t       st_d, st_q;
    logic [DW-1:0] set_v;
    logic [DW-1:0] mode_word;
    logic          det_mc, det_pw;
    logic [DW-1:0] err_words [NPORTS];
    logic [DW-1:0] ctl_words [NPORTS];
    logic [NPORTS-1:0] port_det;

    sev_mode_src mode_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_mc  (ev_mcast_i),
        .ev_pw  (ev_pwrite_i),
        .we     (wr_en_i && wr_addr_i == A_MODE),
        .wdata  (wr_data_i),
        .word   (mode_word),
        .det_mc (det_mc),
        .det_pw (det_pw)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        localparam logic [AW-1:0] ERR_A = AW'(PORT_BASE + 2 * p);
        localparam logic [AW-1:0] CTL_A = AW'(PORT_BASE + 2 * p + 1);
        logic [NSRC-1:0] ev;
        always_comb begin
            ev          = '0;
            ev[S_FATAL] = pe_fatal_i[p];
            ev[S_DEGR]  = pe_degr_i[p];
            ev[S_FAIL]  = pe_fail_i[p];
            ev[S_ILLEG] = pe_illeg_i[p];
            ev[S_RETRY] = pe_retry_i[p];
        end
        sev_port_err port_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev       (ev),
            .err_we   (wr_en_i && wr_addr_i == ERR_A),
            .ctl_we   (wr_en_i && wr_addr_i == CTL_A),
            .wdata    (wr_data_i),
            .err_word (err_words[p]),
            .ctl_word (ctl_words[p]),
            .detect   (port_det[p])
        );
    end

    always_comb begin
        set_v          = '0;
        set_v[B_MCAST] = det_mc;
        set_v[B_PWR]   = det_pw;
        for (int p = 0; p < NPORTS; p++) set_v[B_PERR0+p] = port_det[p];

        st_d = st_q;
        if (wr_en_i && wr_addr_i == A_CLR) st_d.stat = st_q.stat & ~wr_data_i;
        st_d.stat = (st_d.stat | set_v) & MASK;
        if (wr_en_i && wr_addr_i == A_EN) st_d.en = wr_data_i & MASK;

        irq_o = |(st_q.stat & st_q.en);

        rd_data_o = '0;
        case (rd_addr_i)
            A_STAT:  rd_data_o = st_q.stat;
            A_EN:    rd_data_o = st_q.en;
            A_MODE:  rd_data_o = mode_word;
            default: begin
                for (int p = 0; p < NPORTS; p++) begin
                    if (rd_addr_i == AW'(PORT_BASE + 2 * p))     rd_data_o = err_words[p];
                    if (rd_addr_i == AW'(PORT_BASE + 2 * p + 1)) rd_data_o = ctl_words[p];
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar b = 0; b < DW; b++) begin : g_chk
        if (MASK[b]) begin : g_impl
            // R4
            stat_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(st_q.stat[b]) |-> $past(wr_en_i && wr_addr_i == A_CLR && wr_data_i[b]));
            // R7
            set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set_v[b] |=> st_q.stat[b]);
        end
    end

    // R8
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en == '0) |-> !irq_o);
endmodule

// File: tb/sev_aggregator_tb_top.sv
module sev_aggregator_tb_top;
    localparam int NP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [3:0]    rd_addr = '0;
    logic [31:0]   rd_data;
    logic          ev_mc = 1'b0, ev_pw = 1'b0;
    logic [NP-1:0] pf = '0, pd = '0, pl = '0, pi = '0, pr = '0;
    logic          irq;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sev_aggregator #(.NPORTS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .ev_mcast_i(ev_mc), .ev_pwrite_i(ev_pw),
        .pe_fatal_i(pf), .pe_degr_i(pd), .pe_fail_i(pl),
        .pe_illeg_i(pi), .pe_retry_i(pr),
        .irq_o(irq)
    );

    task automatic chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        rd_addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s addr %0d actual %h expected %h", req, a, rd_data, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string req);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq actual %b expected %b", req, irq, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_src(input int p, input int k, input logic v);
        case (k)
            0: pf[p] = v;
            1: pd[p] = v;
            2: pl[p] = v;
            3: pi[p] = v;
            default: pr[p] = v;
        endcase
    endtask

    task automatic pulse_port(input int p, input int k);
        @(negedge clk);
        set_src(p, k, 1'b1);
        @(negedge clk);
        set_src(p, k, 1'b0);
    endtask

    task automatic pulse_glob(input bit mc);
        @(negedge clk);
        if (mc) ev_mc = 1'b1; else ev_pw = 1'b1;
        @(negedge clk);
        ev_mc = 1'b0; ev_pw = 1'b0;
    endtask

    function automatic logic [31:0] src_bit(input int k);
        case (k)
            0: return 32'h0000_0004;
            1: return 32'h0100_0000;
            2: return 32'h0200_0000;
            3: return 32'h0010_0000;
            default: return 32'h0001_0000;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 10; a++) chk(4'(a), 32'h0, "R1");
        chk_irq(1'b0, "R1");

        // R9: enable readback, unimplemented bits dropped
        wr(4'd2, 32'hFFFF_FFFF);
        chk(4'd2, 32'h0000_0703, "R9");

        // R2 multicast, R8 interrupt
        pulse_glob(1'b1);
        chk(4'd0, 32'h1, "R2");
        chk(4'd3, 32'h10, "R2");
        chk_irq(1'b1, "R8");
        // R4: writing 0 to the clear register has no effect
        wr(4'd1, 32'h0);
        chk(4'd0, 32'h1, "R4");
        wr(4'd1, 32'h1);
        chk(4'd0, 32'h0, "R4");
        chk_irq(1'b0, "R8");
        // R5: no re-detection while mode bit is set
        pulse_glob(1'b1);
        chk(4'd0, 32'h0, "R5");
        wr(4'd3, 32'h0);
        chk(4'd3, 32'h10, "R9");
        wr(4'd3, 32'h10);
        chk(4'd3, 32'h0, "R5");
        pulse_glob(1'b1);
        chk(4'd0, 32'h1, "R5");

        // R2 port-write
        pulse_glob(1'b0);
        chk(4'd0, 32'h3, "R2");
        chk(4'd3, 32'h11, "R2");
        wr(4'd1, 32'h2);
        pulse_glob(1'b0);
        chk(4'd0, 32'h1, "R5");
        wr(4'd3, 32'h1);
        pulse_glob(1'b0);
        chk(4'd0, 32'h3, "R5");
        wr(4'd3, 32'h11);
        wr(4'd1, 32'h3);
        chk(4'd0, 32'h0, "R4");

        // R3, R6 sweep over ports and source kinds
        for (int p = 0; p < NP; p++) begin
            for (int k = 0; k < 5; k++) begin
                logic [3:0]  ea, ca;
                logic [31:0] eb, cb, e2, c2;
                int k2;
                ea = 4'(4 + 2 * p);
                ca = 4'(5 + 2 * p);
                k2 = (k + 1) % 5;
                eb = (k < 3) ? src_bit(k) : 32'h0;
                cb = (k < 3) ? 32'h40 : (src_bit(k) | 32'h40);
                pulse_port(p, k);
                chk(4'd0, 32'h1 << (8 + p), "R3");
                chk(ea, eb, "R3");
                chk(ca, cb, "R3");
                chk_irq(1'b1, "R8");
                wr(4'd1, 32'h1 << (8 + p));
                pulse_port(p, k2);
                chk(4'd0, 32'h0, "R6");
                e2 = eb | ((k2 < 3) ? src_bit(k2) : 32'h0);
                c2 = cb | ((k2 < 3) ? 32'h0 : src_bit(k2));
                chk(ea, e2, "R3");
                chk(ca, c2, "R3");
                // R9: writing 0 leaves sticky bits alone
                wr(ea, 32'h0);
                wr(ca, 32'h0);
                chk(ea, e2, "R9");
                chk(ca, c2, "R9");
                // R6: summary clear while sources set does not stick
                wr(ca, 32'h40);
                chk(ca, c2, "R6");
                wr(ea, 32'h0300_0004);
                wr(ca, 32'h0011_0000);
                chk(ea, 32'h0, "R6");
                chk(ca, 32'h40, "R6");
                pulse_port(p, k);
                chk(4'd0, 32'h0, "R6");
                wr(ea, 32'h0300_0004);
                wr(ca, 32'h0011_0000);
                wr(ca, 32'h40);
                chk(ca, 32'h0, "R6");
                pulse_port(p, k);
                chk(4'd0, 32'h1 << (8 + p), "R6");
                wr(4'd1, 32'h700);
                wr(ea, 32'h0300_0004);
                wr(ca, 32'h0011_0000);
                wr(ca, 32'h40);
            end
        end

        // R7: set wins over clear in the same cycle (status and sticky)
        @(negedge clk);
        ev_mc = 1'b1; wr_en = 1'b1; wr_addr = 4'd1; wr_data = 32'h1;
        @(negedge clk);
        ev_mc = 1'b0; wr_en = 1'b0;
        chk(4'd0, 32'h1, "R7");
        @(negedge clk);
        ev_mc = 1'b1; wr_en = 1'b1; wr_addr = 4'd3; wr_data = 32'h10;
        @(negedge clk);
        ev_mc = 1'b0; wr_en = 1'b0;
        chk(4'd3, 32'h10, "R7");

        // R8: masked status raises no interrupt
        wr(4'd2, 32'h0);
        chk(4'd0, 32'h1, "R8");
        chk_irq(1'b0, "R8");
        wr(4'd2, 32'h2);
        chk_irq(1'b0, "R8");
        wr(4'd2, 32'h1);
        chk_irq(1'b1, "R8");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule